// File: doc/BRIEF.md
# Transfer Address and Count Sequencer

This block keeps the running state of one transfer descriptor for a data transfer controller. A descriptor load writes a 24-bit source address, a 24-bit destination address, two 16-bit count words (A and B), a mode, a transfer size and two address-hold enables. After that, every transfer strobe moves the addresses forward and updates the counters the way the mode requires. The block raises a one-cycle completion flag on the strobe that performs the last transfer.

There are three modes. Normal mode uses count word A as a single 16-bit transfer counter. Repeat mode splits A into an 8-bit reload value (upper byte) and an 8-bit running counter (lower byte). Each time the running counter wraps, it reloads and both addresses go back to their loaded start values, so repeat mode never completes. Block mode splits A the same way, so the lower byte counts transfers within a block, and count word B counts blocks down to the end of the whole operation. The live register values are always visible on the outputs. The controller uses them to drive its bus cycles and to write the descriptor back.

Top module: `xfer_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no load, the address, count, active, done and error outputs are all zero.
- R2: A load takes the descriptor into src_o, dst_o, cnt_a_o and cnt_b_o on the next clock edge. A strobe in the same cycle as a load has no effect.
- R3: An accepted strobe adds 1 to each address for byte size (ld_word_i=0) and 2 for word size (ld_word_i=1). An address whose hold enable was loaded as 1 stays where it is. Addresses wrap modulo 2^24.
- R4: A load with word size and an odd source or destination address sets addr_err_o, which stays set until the next load. It leaves active_o low, so strobes are ignored. Odd addresses with byte size are accepted.
- R5: Mode encoding is 0 normal, 1 repeat, 2 block, and 3 acts as normal. In normal mode each accepted strobe decrements cnt_a_o by 1 over all 16 bits. A loaded 0 stands for 65536 and steps to 0xFFFF.
- R6: In normal mode, the strobe that takes cnt_a_o from 1 to 0 completes the descriptor. done_o is then high and active_o low after that edge.
- R7: In repeat and block modes, each accepted strobe decrements only cnt_a_o[7:0]. When the strobe finds that byte at 1, the byte reloads from cnt_a_o[15:8]. The upper byte never changes, and a value of 0 in either byte stands for 256.
- R8: In repeat mode, a strobe that reloads the lower byte also returns both addresses to their loaded start values. done_o never goes high in repeat mode.
- R9: In block mode, each lower-byte reload decrements cnt_b_o by 1 (a loaded 0 stands for 65536). The reload that takes cnt_b_o from 1 to 0 completes the descriptor.
- R10: Once a descriptor is complete, strobes change no output until the next load.
- R11: done_o is high for exactly one cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load descriptor |
| ld_mode_i | input | 2 | Mode: 0 normal, 1 repeat, 2 block, 3 normal |
| ld_word_i | input | 1 | Transfer size: 1 word, 0 byte |
| ld_src_hold_i | input | 1 | Keep source address fixed |
| ld_dst_hold_i | input | 1 | Keep destination address fixed |
| ld_src_i | input | 24 | Source start address |
| ld_dst_i | input | 24 | Destination start address |
| ld_cnt_a_i | input | 16 | Count word A |
| ld_cnt_b_i | input | 16 | Count word B (block count) |
| strobe_i | input | 1 | One transfer performed |
| src_o | output | 24 | Live source address |
| dst_o | output | 24 | Live destination address |
| cnt_a_o | output | 16 | Live count word A |
| cnt_b_o | output | 16 | Live count word B |
| active_o | output | 1 | Descriptor accepted and not yet complete |
| done_o | output | 1 | Completion pulse |
| addr_err_o | output | 1 | Odd address loaded with word size |

## Verification
The assertions take load_i and strobe_i as clean synchronous levels that are sampled only at the rising edge. They also take the registered mode as a stand-in for the mode of the strobe that produced a pulse, which holds because a load always blocks a strobe in the same cycle. The bench changes every input only on the falling edge and keeps each descriptor's fields stable while load_i is high. It also puts strobes only on cycles where the expected state has been worked out from the requirements. Where a vector covers a completion, it stops the strobe train on the completing strobe, so the pulse count stays tied to the requirement.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'd0,
    XM_REPEAT = 2'd1,
    XM_BLOCK  = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  // Lower/upper split of count word A applies in repeat and block modes
  function automatic logic mode_split(xfer_mode_e m);
    return (m == XM_REPEAT) || (m == XM_BLOCK);
  endfunction
endpackage

// File: rtl/xfer_addr_unit.sv
module xfer_addr_unit #(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_hold_i,
  input  logic          word_i,
  input  logic          step_i,
  input  logic          restore_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, start_q;
  logic          hold_q;
  logic [AW-1:0] inc;

  assign inc = word_i ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
      hold_q  <= 1'b0;
    end else if (load_i) begin
      addr_q  <= ld_addr_i;
      start_q <= ld_addr_i;
      hold_q  <= ld_hold_i;
    end else if (step_i) begin
      if (restore_i)   addr_q <= start_q;
      else if (!hold_q) addr_q <= addr_q + inc;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/xfer_cnt_unit.sv
module xfer_cnt_unit
  import xfer_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] ld_a_i,
  input  logic [CW-1:0] ld_b_i,
  input  xfer_mode_e    mode_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_a_o,
  output logic [CW-1:0] cnt_b_o,
  output logic          wrap_o,
  output logic          last_o
);
  localparam int HW = CW / 2;
  localparam logic [CW-1:0] ONE_F = CW'(1);
  localparam logic [HW-1:0] ONE_H = HW'(1);

  logic [CW-1:0] a_q, b_q;
  logic [HW-1:0] lo, hi;
  logic          split, lo_last;

  assign lo      = a_q[HW-1:0];
  assign hi      = a_q[CW-1:HW];
  assign split   = mode_split(mode_i);
  assign lo_last = (lo == ONE_H);
  assign wrap_o  = split && lo_last;

  always_comb begin
    unique case (mode_i)
      XM_REPEAT: last_o = 1'b0;
      XM_BLOCK:  last_o = lo_last && (b_q == ONE_F);
      default:   last_o = (a_q == ONE_F);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= ld_a_i;
      b_q <= ld_b_i;
    end else if (step_i) begin
      if (!split)       a_q <= a_q - ONE_F;
      else if (lo_last) a_q[HW-1:0] <= hi;
      else              a_q[HW-1:0] <= lo - ONE_H;
      if (mode_i == XM_BLOCK && lo_last) b_q <= b_q - ONE_F;
    end
  end

  assign cnt_a_o = a_q;
  assign cnt_b_o = b_q;
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import xfer_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  xfer_mode_e ld_mode_i,
  input  logic       ld_word_i,
  input  logic       ld_err_i,
  input  logic       strobe_i,
  input  logic       last_i,
  output logic       step_o,
  output xfer_mode_e mode_o,
  output logic       word_o,
  output logic       active_o,
  output logic       done_o,
  output logic       err_o
);
  xfer_mode_e mode_q;
  logic       word_q, active_q, done_q, err_q;

  // load wins over strobe
  assign step_o = strobe_i && active_q && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= XM_NORMAL;
      word_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= step_o && last_i;
      if (load_i) begin
        mode_q   <= ld_mode_i;
        word_q   <= ld_word_i;
        err_q    <= ld_err_i;
        active_q <= !ld_err_i;
      end else if (step_o && last_i) begin
        active_q <= 1'b0;
      end
    end
  end

  assign mode_o   = mode_q;
  assign word_o   = word_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    ld_mode_i,
  input  logic          ld_word_i,
  input  logic          ld_src_hold_i,
  input  logic          ld_dst_hold_i,
  input  logic [AW-1:0] ld_src_i,
  input  logic [AW-1:0] ld_dst_i,
  input  logic [CW-1:0] ld_cnt_a_i,
  input  logic [CW-1:0] ld_cnt_b_i,
  input  logic          strobe_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_a_o,
  output logic [CW-1:0] cnt_b_o,
  output logic          active_o,
  output logic          done_o,
  output logic          addr_err_o
);
  localparam int NADDR = 2;

  xfer_mode_e    mode_q;
  logic          word_q, step, wrap, last, ld_err, restore;
  logic [AW-1:0] ld_addr [NADDR];
  logic          ld_hold [NADDR];
  logic [AW-1:0] addr    [NADDR];

  assign ld_addr[0] = ld_src_i;
  assign ld_addr[1] = ld_dst_i;
  assign ld_hold[0] = ld_src_hold_i;
  assign ld_hold[1] = ld_dst_hold_i;
  assign ld_err     = ld_word_i && (ld_src_i[0] || ld_dst_i[0]);
  assign restore    = (mode_q == XM_REPEAT) && wrap;

  xfer_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .ld_mode_i (xfer_mode_e'(ld_mode_i)),
    .ld_word_i (ld_word_i),
    .ld_err_i  (ld_err),
    .strobe_i  (strobe_i),
    .last_i    (last),
    .step_o    (step),
    .mode_o    (mode_q),
    .word_o    (word_q),
    .active_o  (active_o),
    .done_o    (done_o),
    .err_o     (addr_err_o)
  );

  xfer_cnt_unit #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .ld_a_i  (ld_cnt_a_i),
    .ld_b_i  (ld_cnt_b_i),
    .mode_i  (mode_q),
    .step_i  (step),
    .cnt_a_o (cnt_a_o),
    .cnt_b_o (cnt_b_o),
    .wrap_o  (wrap),
    .last_o  (last)
  );

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    xfer_addr_unit #(.AW(AW)) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .ld_addr_i (ld_addr[g]),
      .ld_hold_i (ld_hold[g]),
      .word_i    (word_q),
      .step_i    (step),
      .restore_i (restore),
      .addr_o    (addr[g])
    );
  end

  assign src_o = addr[0];
  assign dst_o = addr[1];
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          strobe_i,
  input logic [AW-1:0] ld_src_i,
  input logic [CW-1:0] ld_cnt_a_i,
  input logic [AW-1:0] src_o,
  input logic [AW-1:0] dst_o,
  input logic [CW-1:0] cnt_a_o,
  input logic [CW-1:0] cnt_b_o,
  input logic          active_o,
  input logic          done_o,
  input logic          addr_err_o,
  input logic [1:0]    mode_q
);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o);

  a_r4_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !active_o);

  a_r8_repeat_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1) |-> !done_o);

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (src_o == $past(ld_src_i)) && (cnt_a_o == $past(ld_cnt_a_i)));

  a_r10_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !load_i) |=> ($stable(src_o) && $stable(dst_o)
                                && $stable(cnt_a_o) && $stable(cnt_b_o)));

  a_r5_normal_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && active_o && !load_i && (mode_q == 2'd0 || mode_q == 2'd3))
      |=> (cnt_a_o == $past(cnt_a_o) - CW'(1)));
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .strobe_i   (strobe_i),
  .ld_src_i   (ld_src_i),
  .ld_cnt_a_i (ld_cnt_a_i),
  .src_o      (src_o),
  .dst_o      (dst_o),
  .cnt_a_o    (cnt_a_o),
  .cnt_b_o    (cnt_b_o),
  .active_o   (active_o),
  .done_o     (done_o),
  .addr_err_o (addr_err_o),
  .mode_q     (mode_q)
);

// File: tb/xfer_seq_bench.sv
`timescale 1ns/1ps
module xfer_seq_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, load_i = 1'b0, strobe_i = 1'b0;
  logic [1:0]  ld_mode_i = '0;
  logic        ld_word_i = 1'b0, ld_src_hold_i = 1'b0, ld_dst_hold_i = 1'b0;
  logic [23:0] ld_src_i = '0, ld_dst_i = '0, src_o, dst_o;
  logic [15:0] ld_cnt_a_i = '0, ld_cnt_b_i = '0, cnt_a_o, cnt_b_o;
  logic        active_o, done_o, addr_err_o;
  int nchk = 0, nfail = 0;

  always #5 clk_i = ~clk_i;

  xfer_seq u_xfer_seq (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        word, shold, dhold;
    logic [23:0] src, dst;
    logic [15:0] ca, cb;
    logic [7:0]  n;
    logic [23:0] e_src, e_dst;
    logic [15:0] e_ca, e_cb;
    logic        e_act;
    logic [7:0]  e_done;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R3 R5 normal byte
    '{2'd0,1'b0,1'b0,1'b0,24'h001000,24'h002000,16'd5,16'd0,8'd3,24'h001003,24'h002003,16'd2,16'd0,1'b1,8'd0},
    // R3 R6 normal word to completion
    '{2'd0,1'b1,1'b0,1'b0,24'h000100,24'h000200,16'd4,16'd0,8'd4,24'h000108,24'h000208,16'd0,16'd0,1'b0,8'd1},
    // R3 destination held
    '{2'd0,1'b1,1'b0,1'b1,24'h000010,24'h000040,16'd10,16'd0,8'd2,24'h000014,24'h000040,16'd8,16'd0,1'b1,8'd0},
    // R7 repeat before wrap
    '{2'd1,1'b0,1'b0,1'b0,24'h000500,24'h000600,16'h0303,16'd0,8'd2,24'h000502,24'h000602,16'h0301,16'd0,1'b1,8'd0},
    // R8 repeat wrap restores addresses
    '{2'd1,1'b0,1'b0,1'b0,24'h000500,24'h000600,16'h0303,16'd0,8'd3,24'h000500,24'h000600,16'h0303,16'd0,1'b1,8'd0},
    // R8 repeat word, source held, past a wrap
    '{2'd1,1'b1,1'b1,1'b0,24'h000700,24'h000800,16'h0402,16'd0,8'd4,24'h000700,24'h000804,16'h0402,16'd0,1'b1,8'd0},
    // R9 block in progress
    '{2'd2,1'b0,1'b0,1'b0,24'h000000,24'h000100,16'h0202,16'd3,8'd4,24'h000004,24'h000104,16'h0202,16'd1,1'b1,8'd0},
    // R9 block to completion
    '{2'd2,1'b1,1'b0,1'b0,24'h001000,24'h002000,16'h0202,16'd2,8'd4,24'h001008,24'h002008,16'h0202,16'd0,1'b0,8'd1},
    // R3 address wrap at 2^24
    '{2'd0,1'b0,1'b0,1'b0,24'hFFFFFF,24'hFFFFFE,16'd3,16'd0,8'd2,24'h000001,24'h000000,16'd1,16'd0,1'b1,8'd0},
    // R5 mode 3 acts as normal
    '{2'd3,1'b0,1'b0,1'b0,24'h000000,24'h000000,16'd2,16'd0,8'd2,24'h000002,24'h000002,16'd0,16'd0,1'b0,8'd1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] m, input logic w, input logic sh, input logic dh,
                         input logic [23:0] s, input logic [23:0] d,
                         input logic [15:0] a, input logic [15:0] b, input logic with_strobe);
    @(negedge clk_i);
    ld_mode_i = m; ld_word_i = w; ld_src_hold_i = sh; ld_dst_hold_i = dh;
    ld_src_i = s; ld_dst_i = d; ld_cnt_a_i = a; ld_cnt_b_i = b;
    load_i = 1'b1; strobe_i = with_strobe;
    @(negedge clk_i);
    load_i = 1'b0; strobe_i = 1'b0;
  endtask

  task automatic do_strobes(input int n, output int dones);
    dones = 0;
    for (int i = 0; i < n; i++) begin
      strobe_i = 1'b1;
      @(negedge clk_i);
      if (done_o) dones++;
    end
    strobe_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int dn;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "src in reset", 32'(src_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "outputs after reset",
        {8'(cnt_a_o[7:0] | cnt_b_o[7:0]), 8'(dst_o[7:0]), 5'd0, active_o, done_o, addr_err_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      do_load(t.mode, t.word, t.shold, t.dhold, t.src, t.dst, t.ca, t.cb, 1'b0);
      do_strobes(int'(t.n), dn);
      chk("R3", $sformatf("vec%0d src", v), 32'(src_o), 32'(t.e_src));
      chk("R3", $sformatf("vec%0d dst", v), 32'(dst_o), 32'(t.e_dst));
      chk("R7", $sformatf("vec%0d cnt_a", v), 32'(cnt_a_o), 32'(t.e_ca));
      chk("R9", $sformatf("vec%0d cnt_b", v), 32'(cnt_b_o), 32'(t.e_cb));
      chk("R6", $sformatf("vec%0d active", v), 32'(active_o), 32'(t.e_act));
      chk("R11", $sformatf("vec%0d done count", v), 32'(dn), 32'(t.e_done));
    end

    // R5 zero means 65536
    do_load(2'd0, 1'b0, 1'b0, 1'b0, 24'h10, 24'h20, 16'h0000, 16'h0, 1'b0);
    do_strobes(1, dn);
    chk("R5", "cnt_a from 0", 32'(cnt_a_o), 32'hFFFF);
    chk("R5", "active after 0 load", 32'(active_o), 32'h1);

    // R6 R11 R10 completion pulse and freeze
    do_load(2'd0, 1'b0, 1'b0, 1'b0, 24'h30, 24'h40, 16'h0001, 16'h0, 1'b0);
    do_strobes(1, dn);
    chk("R6", "done on last strobe", 32'(dn), 32'h1);
    chk("R6", "active dropped", 32'(active_o), 32'h0);
    @(negedge clk_i);
    chk("R11", "done one cycle", 32'(done_o), 32'h0);
    do_strobes(3, dn);
    chk("R10", "no done after completion", 32'(dn), 32'h0);
    chk("R10", "src frozen", 32'(src_o), 32'h31);
    chk("R10", "cnt_a frozen", 32'(cnt_a_o), 32'h0);

    // R4 odd address with word size
    do_load(2'd0, 1'b1, 1'b0, 1'b0, 24'h51, 24'h60, 16'd5, 16'h0, 1'b0);
    chk("R4", "err flag", 32'(addr_err_o), 32'h1);
    do_strobes(2, dn);
    chk("R4", "src ignored", 32'(src_o), 32'h51);
    chk("R4", "cnt ignored", 32'(cnt_a_o), 32'd5);
    do_load(2'd0, 1'b0, 1'b0, 1'b0, 24'h51, 24'h63, 16'd5, 16'h0, 1'b0);
    chk("R4", "byte odd ok", {30'd0, addr_err_o, active_o}, 32'h1);
    do_load(2'd0, 1'b1, 1'b0, 1'b0, 24'h50, 24'h63, 16'd5, 16'h0, 1'b0);
    chk("R4", "odd destination word", 32'(addr_err_o), 32'h1);

    // R2 load wins over strobe
    do_load(2'd0, 1'b0, 1'b0, 1'b0, 24'h0ABCDE, 24'h012345, 16'd9, 16'd7, 1'b1);
    chk("R2", "src", 32'(src_o), 32'h0ABCDE);
    chk("R2", "dst", 32'(dst_o), 32'h012345);
    chk("R2", "cnt_a", 32'(cnt_a_o), 32'd9);
    chk("R2", "cnt_b", 32'(cnt_b_o), 32'd7);

    // R8 repeat never completes
    do_load(2'd1, 1'b0, 1'b0, 1'b0, 24'h100, 24'h200, 16'h0101, 16'h0, 1'b0);
    do_strobes(5, dn);
    chk("R8", "no done in repeat", 32'(dn), 32'h0);
    chk("R8", "still active", 32'(active_o), 32'h1);
    chk("R8", "src restored", 32'(src_o), 32'h100);

    // R7 reload value 0 means 256
    do_load(2'd1, 1'b0, 1'b0, 1'b0, 24'h0, 24'h0, 16'h0001, 16'h0, 1'b0);
    do_strobes(1, dn);
    chk("R7", "reload zero", 32'(cnt_a_o), 32'h0000);
    do_strobes(1, dn);
    chk("R7", "256 step", 32'(cnt_a_o), 32'h00FF);

    // R9 block count 0 means 65536
    do_load(2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 24'h0, 16'h0101, 16'h0000, 1'b0);
    do_strobes(1, dn);
    chk("R9", "cnt_b from 0", 32'(cnt_b_o), 32'hFFFF);
    chk("R9", "no done", 32'(dn), 32'h0);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #2;
    chk("R1", "reset clears", {8'(cnt_b_o[7:0]), 8'(src_o[7:0]), 15'd0, active_o}, 32'h0);
    summary();
  end
endmodule